// File: doc/BRIEF.md
# Palette Entry Format Converter

This block turns raw 32-bit palette words, as they arrive from a memory fetch, into uniform palette entries of 8 bits per colour channel plus a transparency flag, and stores them in an internal palette RAM. A lookup port reads that RAM for the pixel path. The depth code of the current pixel mode sets how many words make one palette. A 2-bit format selector picks one of four packed source layouts. A monochrome flag copies the low byte of the word into all three channels.

Every raw word is also kept in a shadow buffer. When the format selector later differs from the format last used, the block rebuilds every entry from the stored words without a new fetch. It converts one entry per clock and signals this with `busy`. A one-cycle `done` pulse marks the end of every load and of every rebuild.

Top module: `pal_xlate`

## Requirements
- R1: After reset, `done` and `busy` are both 0.
- R2: With depth code 1, 2 or 3, a palette holds 4, 16 or 256 entries. Each valid word is written at the next address, starting from 0. `done` is high for exactly one cycle, in the cycle after the clock edge that writes the last entry. The next valid word then goes to address 0.
- R3: With any other depth code (0, 4 to 15), valid words are ignored: nothing is written, `done` stays low, and the next load starts at address 0.
- R4: Format 0: red = word[15:11], green = word[10:5], blue = word[4:0]. Each field is left-aligned in 8 bits with zero low bits, and transparency is 0.
- R5: Format 1: the same colour fields as format 0, with transparency = word[24].
- R6: Format 2: red = word[23:19], green = word[15:10], blue = word[7:3]. Each field is left-aligned with zero low bits, and transparency = word[24].
- R7: Format 3: red = word[23:16], green = word[15:8], blue = word[7:0], transparency = word[24].
- R8: When `mono` is 1, red, green and blue all equal word[7:0]. Transparency follows the selected format (0 for format 0, word[24] otherwise).
- R9: An entry is 25 bits: bit 24 transparency, bits 23:16 red, 15:8 green, 7:0 blue. `lookup_entry` shows the entry at the `lookup_addr` value sampled at the previous clock edge.
- R10: A rebuild starts when all of these hold: the block is idle at address 0, a complete palette has been loaded, no word is valid, the depth code is supported, and `pal_fmt` differs from the format last used. The block then converts every stored word with the new format, one per cycle. `busy` is high for as many cycles as the palette has entries, and `done` pulses in the cycle `busy` falls.
- R11: Words presented while `busy` is high are dropped. They change neither the entries nor the stored raw words, and the load after the rebuild starts at address 0.
- R12: While `pal_fmt` equals the format last used, no rebuild starts and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A raw palette word is present this cycle |
| word_data | input | 32 | Raw palette word |
| pal_fmt | input | 2 | Source layout selector, 0 to 3 |
| depth_code | input | 4 | Pixel depth code: 1, 2 or 3 for 2, 4 or 8 bits per pixel |
| mono | input | 1 | Copy the low byte into all three channels |
| lookup_addr | input | 8 | Palette index to read |
| lookup_entry | output | 25 | Entry read one cycle after its address |
| busy | output | 1 | Rebuild in progress |
| done | output | 1 | One-cycle pulse after the last entry of a load or rebuild |

## Verification
A wrong write index shows up as entries at shifted lookup addresses. It can also show up as a `done` pulse one word early or late, which is visible at the edge after the last word. A stale record of the last-used format shows up as a spurious or missing `busy` burst in the first idle cycle after `pal_fmt` changes. A lost raw word shows up only when a rebuild reads it back, so the bench checks every entry after each rebuild. A wrong field slice is caught by readback of words that set each field's edge bits.

// File: rtl/pal_xlate_pkg.sv
package pal_xlate_pkg;
    localparam int WORD_W  = 32;
    localparam int CH_W    = 8;
    localparam int ENT_W   = 3 * CH_W + 1;
    localparam int MAX_ENT = 256;
    localparam int IDX_W   = $clog2(MAX_ENT);
    localparam int CNT_W   = IDX_W + 1;

    typedef enum logic [1:0] {
        FMT_RGB565   = 2'd0,
        FMT_RGB565_T = 2'd1,
        FMT_RGB666_T = 2'd2,
        FMT_RGB888_T = 2'd3
    } fmt_e;

    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_REDO = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic [IDX_W-1:0] idx;
        logic             have;
        logic [CNT_W-1:0] n;
        logic [1:0]       fmt_used;
        logic [1:0]       fmt_redo;
        logic             done;
    } seq_t;

    // Palette size for a pixel depth code; 0 means no palette.
    function automatic logic [CNT_W-1:0] entry_count(input logic [3:0] code);
        case (code)
            4'd1:    entry_count = CNT_W'(4);
            4'd2:    entry_count = CNT_W'(16);
            4'd3:    entry_count = CNT_W'(256);
            default: entry_count = '0;
        endcase
    endfunction
endpackage

// File: rtl/pal_widen.sv
module pal_widen
    import pal_xlate_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        fmt,
    input  logic              mono,
    output logic [ENT_W-1:0]  entry
);
    logic [CH_W-1:0] r, g, b;
    logic            t;
    logic            unused_hi;

    assign unused_hi = ^word[WORD_W-1:25];

    always_comb begin
        t = (fmt == FMT_RGB565) ? 1'b0 : word[24];
        case (fmt)
            FMT_RGB565, FMT_RGB565_T: begin
                r = {word[15:11], 3'b000};
                g = {word[10:5],  2'b00};
                b = {word[4:0],   3'b000};
            end
            FMT_RGB666_T: begin
                r = {word[23:19], 3'b000};
                g = {word[15:10], 2'b00};
                b = {word[7:3],   3'b000};
            end
            default: begin
                r = word[23:16];
                g = word[15:8];
                b = word[7:0];
            end
        endcase
        if (mono) begin
            r = word[7:0];
            g = word[7:0];
            b = word[7:0];
        end
        entry = {t, r, g, b};
    end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int W       = 32,
    parameter int DEPTH   = 256,
    parameter bit SYNC_RD = 1'b1
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    generate
        if (SYNC_RD) begin : g_sync
            logic [W-1:0] rd_q;
            always_ff @(posedge clk) begin
                rd_q <= mem[raddr];
            end
            assign rdata = rd_q;
        end else begin : g_async
            assign rdata = mem[raddr];
        end
    endgenerate
endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic [1:0]        pal_fmt,
    input  logic [3:0]        depth_code,
    input  logic [WORD_W-1:0] raw_rd,
    output logic              raw_we,
    output logic              ent_we,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] src_word,
    output logic [1:0]        use_fmt,
    output logic              busy,
    output logic              done
);
    seq_t             s_d, s_q;
    logic [CNT_W-1:0] n_cur;
    logic [CNT_W-1:0] idx_ext;

    assign n_cur   = entry_count(depth_code);
    assign idx_ext = CNT_W'(s_q.idx);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        raw_we   = 1'b0;
        ent_we   = 1'b0;
        src_word = word_data;
        use_fmt  = pal_fmt;
        case (s_q.mode)
            MODE_IDLE: begin
                if (n_cur == '0) begin
                    s_d.idx = '0;
                end else if (word_valid) begin
                    raw_we       = 1'b1;
                    ent_we       = 1'b1;
                    s_d.fmt_used = pal_fmt;
                    if (idx_ext == n_cur - CNT_W'(1)) begin
                        s_d.idx  = '0;
                        s_d.done = 1'b1;
                        s_d.have = 1'b1;
                        s_d.n    = n_cur;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else if (s_q.have && s_q.idx == '0 && pal_fmt != s_q.fmt_used) begin
                    s_d.mode     = MODE_REDO;
                    s_d.fmt_redo = pal_fmt;
                    s_d.fmt_used = pal_fmt;
                end
            end
            default: begin
                src_word = raw_rd;
                use_fmt  = s_q.fmt_redo;
                ent_we   = 1'b1;
                if (idx_ext == s_q.n - CNT_W'(1)) begin
                    s_d.idx  = '0;
                    s_d.mode = MODE_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_IDLE, idx: '0, have: 1'b0, n: '0,
                     fmt_used: 2'd0, fmt_redo: 2'd0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign idx  = s_q.idx;
    assign busy = (s_q.mode == MODE_REDO);
    assign done = s_q.done;
endmodule

// File: rtl/pal_xlate.sv
module pal_xlate
    import pal_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    input  logic [1:0]  pal_fmt,
    input  logic [3:0]  depth_code,
    input  logic        mono,
    input  logic [7:0]  lookup_addr,
    output logic [24:0] lookup_entry,
    output logic        busy,
    output logic        done
);
    logic              raw_we, ent_we;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] raw_rd, src_word;
    logic [1:0]        use_fmt;
    logic [ENT_W-1:0]  ent_wdata;

    pal_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .pal_fmt    (pal_fmt),
        .depth_code (depth_code),
        .raw_rd     (raw_rd),
        .raw_we     (raw_we),
        .ent_we     (ent_we),
        .idx        (idx),
        .src_word   (src_word),
        .use_fmt    (use_fmt),
        .busy       (busy),
        .done       (done)
    );

    pal_widen u_widen (
        .word  (src_word),
        .fmt   (use_fmt),
        .mono  (mono),
        .entry (ent_wdata)
    );

    pal_store #(.W(WORD_W), .DEPTH(MAX_ENT), .SYNC_RD(1'b0)) u_raw (
        .clk   (clk),
        .we    (raw_we),
        .waddr (idx),
        .wdata (word_data),
        .raddr (idx),
        .rdata (raw_rd)
    );

    pal_store #(.W(ENT_W), .DEPTH(MAX_ENT), .SYNC_RD(1'b1)) u_ent (
        .clk   (clk),
        .we    (ent_we),
        .waddr (idx),
        .wdata (ent_wdata),
        .raddr (lookup_addr),
        .rdata (lookup_entry)
    );
endmodule

// File: rtl/pal_xlate_chk.sv
module pal_xlate_chk (
    input logic clk,
    input logic rst_n,
    input logic word_valid,
    input logic busy,
    input logic done
);
    // R2: done is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done only follows a write cycle or a rebuild cycle
    a_r2_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(word_valid) || $past(busy)));

    // R10: a rebuild starts only after a cycle with no valid word
    a_r10_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(word_valid));

    // R10: the end of a rebuild is marked by done
    a_r10_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: a rebuild covers at least the smallest palette
    a_r10_busy_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
endmodule

bind pal_xlate pal_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .busy       (busy),
    .done       (done)
);

// File: tb/pal_xlate_bench.sv
module pal_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic [1:0]  pal_fmt = 2'd0;
    logic [3:0]  depth_code = 4'd1;
    logic        mono = 1'b0;
    logic [7:0]  lookup_addr = '0;
    logic [24:0] lookup_entry;
    logic        busy, done;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] exp_raw [256];
    logic [24:0] exp_ent [256];
    logic [31:0] lst [4];

    always #4 clk = ~clk;

    pal_xlate u_pal_xlate (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    function automatic logic [24:0] ref_entry(input logic [31:0] w, input logic [1:0] f, input logic m);
        logic [7:0] r, g, b;
        logic t;
        t = (f == 2'd0) ? 1'b0 : w[24];
        if (f == 2'd3) begin
            r = 8'((w >> 16) & 32'hFF); g = 8'((w >> 8) & 32'hFF); b = 8'(w & 32'hFF);
        end else if (f == 2'd2) begin
            r = 8'(((w >> 19) & 32'h1F) << 3); g = 8'(((w >> 10) & 32'h3F) << 2); b = 8'(w & 32'hF8);
        end else begin
            r = 8'(((w >> 11) & 32'h1F) << 3); g = 8'(((w >> 5) & 32'h3F) << 2); b = 8'((w & 32'h1F) << 3);
        end
        if (m) begin
            r = w[7:0]; g = w[7:0]; b = w[7:0];
        end
        return {t, r, g, b};
    endfunction

    task automatic push(input logic [31:0] w, input logic [1:0] f, input logic m);
        pal_fmt = f; mono = m; word_valid = 1'b1; word_data = w;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic read_entry(input int a, output logic [24:0] e);
        lookup_addr = 8'(a);
        @(negedge clk);
        e = lookup_entry;
    endtask

    task automatic verify(input int n, input string tag);
        logic [24:0] e;
        for (int i = 0; i < n; i++) begin
            read_entry(i, e);
            chk($sformatf("%s entry %0d", tag, i), 32'(e), 32'(exp_ent[i]));
        end
    endtask

    task automatic load(input logic [3:0] code, input logic [1:0] f, input logic m,
                        input int n, input logic [31:0] seed, input bit use_list, input string tag);
        depth_code = code;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = use_list ? lst[i] : ((32'(i) * 32'h9E3779B1) ^ seed);
            exp_raw[i] = w;
            exp_ent[i] = ref_entry(w, f, m);
            push(w, f, m);
            if (i == n - 2) chk({tag, " R2 no early done"}, 32'(done), 0);
            if (i == n - 1) chk({tag, " R2 done after last"}, 32'(done), 1);
        end
        @(negedge clk);
        chk({tag, " R2 done one cycle"}, 32'(done), 0);
    endtask

    task automatic t_reset;
        chk("R1 done after reset", 32'(done), 0);
        chk("R1 busy after reset", 32'(busy), 0);
    endtask

    task automatic t_formats;
        logic [24:0] e;
        lst[0] = 32'h0000_F81F; lst[1] = 32'h0100_07E0; lst[2] = 32'h00FF_001F; lst[3] = 32'h01A5_5A3C;
        load(4'd1, 2'd0, 1'b0, 4, 0, 1'b1, "R4");
        verify(4, "R4 fmt0");
        read_entry(0, e);
        chk("R4 R9 fixed 565 layout", 32'(e), 32'h00F8_00F8);
        load(4'd1, 2'd1, 1'b0, 4, 0, 1'b1, "R5");
        verify(4, "R5 fmt1");
        load(4'd1, 2'd2, 1'b0, 4, 0, 1'b1, "R6");
        verify(4, "R6 fmt2");
        lst[0] = 32'h01AB_CDEF;
        load(4'd1, 2'd3, 1'b0, 4, 0, 1'b1, "R7");
        verify(4, "R7 fmt3");
        read_entry(0, e);
        chk("R7 R9 fixed 888 layout", 32'(e), 32'h01AB_CDEF);
        lookup_addr = 8'd1;
        @(negedge clk);
        lookup_addr = 8'd0;
        chk("R9 lookup latency one cycle", 32'(lookup_entry), 32'(exp_ent[1]));
    endtask

    task automatic t_mono;
        logic [24:0] e;
        lst[0] = 32'h0112_345A; lst[1] = 32'h0000_00C3; lst[2] = 32'h01FF_FF00; lst[3] = 32'h0000_FF7E;
        load(4'd1, 2'd3, 1'b1, 4, 0, 1'b1, "R8 fmt3");
        verify(4, "R8 mono fmt3");
        read_entry(0, e);
        chk("R8 fixed mono", 32'(e), 32'h015A_5A5A);
        load(4'd1, 2'd0, 1'b1, 4, 0, 1'b1, "R8 fmt0");
        verify(4, "R8 mono fmt0");
        mono = 1'b0;
    endtask

    task automatic t_no_reparse;
        int cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (busy) cnt++;
        end
        chk("R12 no rebuild with same format", 32'(cnt), 0);
    endtask

    task automatic t_reparse;
        int cnt = 0;
        load(4'd2, 2'd3, 1'b0, 16, 32'h1234_5678, 1'b0, "R10 load");
        chk("R10 idle before change", 32'(busy), 0);
        pal_fmt = 2'd2;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (busy) begin
                cnt++;
                word_valid = 1'b1;
                word_data = 32'hFFFF_FFFF;
            end else begin
                word_valid = 1'b0;
                if (cnt > 0) begin
                    chk("R10 done as busy falls", 32'(done), 1);
                    break;
                end
            end
        end
        word_valid = 1'b0;
        chk("R10 busy cycles", 32'(cnt), 16);
        for (int i = 0; i < 16; i++) exp_ent[i] = ref_entry(exp_raw[i], 2'd2, 1'b0);
        verify(16, "R10 R11 rebuilt entries");
        load(4'd1, 2'd2, 1'b0, 4, 32'h0BAD_F00D, 1'b0, "R11 next load");
        verify(16, "R11 next load at address 0");
    endtask

    task automatic t_unsupported;
        depth_code = 4'd0;
        for (int i = 0; i < 3; i++) begin
            push(32'h0155_AA33 + 32'(i), 2'd2, 1'b0);
            chk("R3 no done at depth 0", 32'(done), 0);
        end
        depth_code = 4'd9;
        for (int i = 0; i < 2; i++) begin
            push(32'h00C0_FFEE + 32'(i), 2'd2, 1'b0);
            chk("R3 no done at depth 9", 32'(done), 0);
        end
        verify(16, "R3 entries untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_mono();
        t_no_reparse();
        t_reparse();
        t_unsupported();
        load(4'd3, 2'd0, 1'b0, 256, 32'h5A5A_0F0F, 1'b0, "R2 256");
        verify(256, "R2 256 entries");
        report();
        $finish;
    end
endmodule